// File: doc/BRIEF.md
# Bus Parity Error Reporter

This block watches a 32-bit multiplexed address/data bus, checks parity on every address phase and on every completed data phase in which this agent is the receiver, and reports errors on two outputs. A data parity failure drives the active-low data error line (`perr_n` with enable `perr_oe`). The line goes low exactly two clocks after the failing data phase, is driven high for one clock after the last error, and is then released. An address parity failure produces a single-clock pull-low on the open-drain system error line (`serr_pull`), also two clocks after the address phase.

The parity bit trails the phase it protects by one clock, and the ones count over the 32 data bits, the 4 command/byte-enable bits and the parity bit together must be even. The surrounding transaction logic supplies qualifiers for the address phase, for the agent taking part in a data phase, for the transfer direction and for the agent's role. The command code sampled at each address phase tells whether the transaction is a broadcast special cycle. Its data is never checked.

Top module: `pci_par_reporter`

## Requirements
- R1: While `rst_n` is low, and in the first clock after it rises, `perr_oe` is 0, `perr_n` is 1 and `serr_pull` is 0.
- R2: A data phase completed at clock edge k is checked against `par` sampled at edge k+1. An odd ones count over `ad`, `cbe_n` and `par` makes `perr_n`=0 and `perr_oe`=1 in the clock that follows edge k+1.
- R3: A data phase is completed only on an edge where `data_phase`=1 and `irdy_n` and `trdy_n` are both 0. Any edge with a wait state is not checked.
- R4: Only the receiving agent checks data. Checking happens when `is_master`=0 with `wr_dir`=1 (target of a write), or when `is_master`=1 with `wr_dir`=0 (master of a read). Otherwise bad data parity has no effect on `perr_n` or `perr_oe`.
- R5: After the last clock with `perr_n` low, the block drives `perr_oe`=1 and `perr_n`=1 for exactly one clock, then sets `perr_oe`=0. The enable never drops while `perr_n` is low.
- R6: Failing data phases on consecutive edges keep `perr_n` low without a gap, and the one-clock high drive follows only the last of them.
- R7: An address phase (`addr_phase`=1) at edge k whose parity, sampled at edge k+1, fails sets `serr_pull`=1 for the single clock after edge k+1. Data parity errors never set `serr_pull`.
- R8: When `cbe_n`=4'b0001 at an address phase, that transaction is a special cycle. Its data phases raise no `perr_n` error, while a failing parity on its address phase is still reported on `serr_pull`.
- R9: With correct parity everywhere, `perr_oe` and `serr_pull` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad | input | 32 | Multiplexed address/data bus |
| cbe_n | input | 4 | Command (address phase) or byte enables (data phase) |
| par | input | 1 | Even parity for the previous clock's `ad` and `cbe_n` |
| addr_phase | input | 1 | This clock is an address phase |
| data_phase | input | 1 | This agent takes part in the current data phase |
| wr_dir | input | 1 | 1 for a write transaction, 0 for a read |
| is_master | input | 1 | 1 when this agent is the bus master, 0 when target |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| perr_n | output | 1 | Data parity error value, low on error |
| perr_oe | output | 1 | Output enable for `perr_n` |
| serr_pull | output | 1 | Pull-low enable for the open-drain system error line |

## Verification
Two reports can land on the same clocks: the data error line and the system error line. The bench provokes this with a fast back-to-back sequence. The last data phase of one transaction fails, and in the very next clock an address phase with bad parity begins. The trailing parity bit of the data then shares a cycle with the new address on the bus. The bench expects `perr_n` low one clock and then the high-drive clock coinciding with the `serr_pull` pulse. Its behavioural model, counting ones, judges every clock of that overlap and of long randomized traffic.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

    // State of one trailing-parity checker: whether a phase is awaiting its
    // parity bit, and the folded parity of the captured phase.
    typedef struct packed {
        logic armed;
        logic fold;
    } chk_state_t;

    // State of the data error line driver.
    typedef struct packed {
        logic low;
        logic hold_high;
    } drv_state_t;

    // Transaction-level state in the top.
    typedef struct packed {
        logic special;
        logic serr;
    } top_state_t;

endpackage

// File: rtl/par_trail_check.sv
module par_trail_check #(
    parameter int WIDTH = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic [WIDTH-1:0] bits,
    input  logic             par,
    output logic             err_o
);
    import pci_par_pkg::*;

    chk_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.armed = sample_en;
        st_d.fold  = ^bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Phase parity must equal the trailing parity bit; mismatch is an error.
    assign err_o = st_q.armed & (st_q.fold ^ par);

    assert_err_after_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(sample_en));

endmodule

// File: rtl/perr_line_drv.sv
module perr_line_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic err_i,
    output logic perr_n,
    output logic perr_oe
);
    import pci_par_pkg::*;

    drv_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.low       = err_i;
        // High drive for one clock only when the low run ends here.
        st_d.hold_high = st_q.low & ~err_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign perr_n  = ~st_q.low;
    assign perr_oe = st_q.low | st_q.hold_high;

    assert_low_stays_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_oe && !perr_n) |=> perr_oe);

    assert_high_drive_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_oe && perr_n) |=> !(perr_oe && perr_n));

    assert_quiet_means_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_oe |-> perr_n);

endmodule

// File: rtl/pci_par_reporter.sv
module pci_par_reporter #(
    parameter int         AD_W        = 32,
    parameter int         BE_W        = 4,
    parameter logic [3:0] SPECIAL_CMD = 4'b0001
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AD_W-1:0] ad,
    input  logic [BE_W-1:0] cbe_n,
    input  logic            par,
    input  logic            addr_phase,
    input  logic            data_phase,
    input  logic            wr_dir,
    input  logic            is_master,
    input  logic            irdy_n,
    input  logic            trdy_n,
    output logic            perr_n,
    output logic            perr_oe,
    output logic            serr_pull
);
    import pci_par_pkg::*;

    localparam int PHASE_W = AD_W + BE_W;

    logic [PHASE_W-1:0] phase_bits;
    logic               completed;
    logic               receiver;
    logic               data_chk_en;
    logic               data_err;
    logic               addr_err;
    top_state_t         st_d, st_q;

    assign phase_bits = {ad, cbe_n};
    assign completed  = data_phase & ~irdy_n & ~trdy_n;
    assign receiver   = is_master ? ~wr_dir : wr_dir;
    assign data_chk_en = completed & receiver & ~st_q.special;

    always_comb begin
        st_d = st_q;
        if (addr_phase) begin
            st_d.special = (cbe_n[3:0] == SPECIAL_CMD);
        end
        st_d.serr = addr_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    par_trail_check #(.WIDTH(PHASE_W)) u_data_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (data_chk_en),
        .bits      (phase_bits),
        .par       (par),
        .err_o     (data_err)
    );

    par_trail_check #(.WIDTH(PHASE_W)) u_addr_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (addr_phase),
        .bits      (phase_bits),
        .par       (par),
        .err_o     (addr_err)
    );

    perr_line_drv u_perr_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_i   (data_err),
        .perr_n  (perr_n),
        .perr_oe (perr_oe)
    );

    assign serr_pull = st_q.serr;

    assert_perr_two_after_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> $past(completed, 2));

    assert_perr_only_receiver_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> $past(receiver, 2));

    assert_serr_two_after_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        serr_pull |-> $past(addr_phase, 2));

endmodule

// File: tb/pci_par_reporter_bench.sv
module pci_par_reporter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        par = 1'b0;
    logic        addr_phase = 1'b0;
    logic        data_phase = 1'b0;
    logic        wr_dir = 1'b0;
    logic        is_master = 1'b0;
    logic        irdy_n = 1'b1;
    logic        trdy_n = 1'b1;
    logic        perr_n;
    logic        perr_oe;
    logic        serr_pull;

    int vectors = 0;
    int misses = 0;
    string tag = "R1";
    logic next_par = 1'b0;
    logic [31:0] lfsr = 32'hACE1_1234;

    // behavioural reference state
    bit m_dpend = 0, m_apend = 0, m_special = 0, m_low = 0;
    int m_dones = 0, m_aones = 0;
    bit e_n = 1, e_oe = 0, e_serr = 0;

    always #5 clk = ~clk;

    pci_par_reporter u_pci_par_reporter (
        .clk(clk), .rst_n(rst_n), .ad(ad), .cbe_n(cbe_n), .par(par),
        .addr_phase(addr_phase), .data_phase(data_phase), .wr_dir(wr_dir),
        .is_master(is_master), .irdy_n(irdy_n), .trdy_n(trdy_n),
        .perr_n(perr_n), .perr_oe(perr_oe), .serr_pull(serr_pull)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dpend = 0; m_apend = 0; m_special = 0; m_low = 0;
            e_n = 1; e_oe = 0; e_serr = 0;
        end else begin
            bit new_low, new_serr, rx;
            new_low  = m_dpend && (((m_dones + int'(par)) % 2) == 1);
            new_serr = m_apend && (((m_aones + int'(par)) % 2) == 1);
            e_oe   = new_low || m_low;
            e_n    = !new_low;
            e_serr = new_serr;
            m_low  = new_low;
            rx = is_master ? !wr_dir : wr_dir;
            m_dpend = data_phase && !irdy_n && !trdy_n && rx && !m_special;
            m_dones = $countones(ad) + $countones(cbe_n);
            m_apend = addr_phase;
            m_aones = m_dones;
            if (addr_phase) m_special = (cbe_n == 4'b0001);
        end
    end

    task automatic compare();
        vectors++;
        if (perr_n !== e_n || perr_oe !== e_oe || serr_pull !== e_serr) begin
            misses++;
            $display("FAIL %s t=%0t perr_n/oe/serr actual %b%b%b expected %b%b%b",
                     tag, $time, perr_n, perr_oe, serr_pull, e_n, e_oe, e_serr);
        end
    endtask

    // One clock: check outputs of the last edge, then drive this cycle.
    task automatic step(input logic [31:0] a, input logic [3:0] c, input bit ap,
                        input bit dp, input bit irdy, input bit trdy, input bit bad);
        @(negedge clk);
        compare();
        par        = next_par;
        ad         = a;
        cbe_n      = c;
        addr_phase = ap;
        data_phase = dp;
        irdy_n     = !irdy;
        trdy_n     = !trdy;
        next_par   = (^{a, c}) ^ bad;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(32'h0, 4'hF, 0, 0, 0, 0, 0);
    endtask

    task automatic addr(input logic [3:0] cmd, input bit bad);
        step(32'h1000_0040, cmd, 1, 0, 0, 0, bad);
    endtask

    task automatic dat(input logic [31:0] v, input bit bad);
        step(v, 4'h0, 0, 1, 1, 1, bad);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        tag = "R1";
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            compare();
        end
        rst_n = 1'b1;
        idle(3);

        tag = "R9"; wr_dir = 1; is_master = 0;
        addr(4'b0111, 0); dat(32'hDEAD_BEEF, 0); dat(32'h0000_0001, 0); idle(4);

        tag = "R2";
        addr(4'b0111, 0); dat(32'h1234_5678, 1); idle(5);

        tag = "R6";
        addr(4'b0111, 0); dat(32'h1, 1); dat(32'h3, 1); dat(32'h7, 1); dat(32'hF, 0); idle(5);

        tag = "R5";
        addr(4'b0111, 0); dat(32'hFFFF_0000, 1); dat(32'h5, 0); idle(2);
        dat(32'h9, 1); idle(5);

        tag = "R3";
        addr(4'b0111, 0);
        step(32'hAAAA_5555, 4'h0, 0, 1, 1, 0, 1);
        step(32'hAAAA_5555, 4'h0, 0, 1, 0, 1, 1);
        step(32'hAAAA_5555, 4'h0, 0, 0, 1, 1, 1);
        dat(32'hAAAA_5555, 0); idle(5);

        tag = "R4";
        is_master = 1; wr_dir = 0;
        addr(4'b0110, 0); dat(32'h77, 1); idle(4);
        wr_dir = 1;
        addr(4'b0111, 0); dat(32'h77, 1); idle(4);
        is_master = 0; wr_dir = 0;
        addr(4'b0110, 0); dat(32'h77, 1); idle(4);
        wr_dir = 1;

        tag = "R7";
        addr(4'b0111, 1); dat(32'h10, 0); idle(4);
        addr(4'b0011, 1); idle(4);

        tag = "R8";
        addr(4'b0001, 0); dat(32'hCAFE_0001, 1); dat(32'hCAFE_0002, 1); idle(4);
        addr(4'b0001, 1); dat(32'h3, 1); idle(4);
        addr(4'b0111, 0); dat(32'h3, 1); idle(5);

        tag = "R7";
        addr(4'b0111, 0); dat(32'h44, 0); dat(32'h45, 1);
        addr(4'b0111, 1); dat(32'h46, 0); idle(5);

        tag = "R2";
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            wr_dir    = lfsr[3];
            is_master = lfsr[9] & lfsr[10];
            step(lfsr, lfsr[7:4], lfsr[12:11] == 2'b00, lfsr[14] | lfsr[15],
                 lfsr[16] | lfsr[17], lfsr[18] | lfsr[19], lfsr[20] & lfsr[21]);
        end
        idle(5);

        tag = "R1";
        rst_n = 1'b0;
        @(negedge clk);
        compare();
        rst_n = 1'b1;
        idle(3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule